// File: doc/BRIEF.md
# Load Replay Filter Tracker

This block sits beside the commit stage of an out-of-order core that checks memory ordering by value. A load that commits may be executed a second time, in program order, and its new value compared with the value it was first given. That second access costs cache bandwidth. This block decides, for each committing load, whether the second access is needed or can safely be skipped.

From the moment a load issues until it commits, the block follows it by a tag (its slot in the load window). At issue it records two flags. The first says whether the load was hoisted ahead of older memory operations. The second says whether any older store still had an unknown address at that moment. Cache line fills and external invalidates are counted by two global epoch counters, and each load takes a copy of both counters at issue. At commit the copies are compared with the live counters, together with a per-slot lap bit, to learn whether a fill or an invalidate happened while the load was in flight. A two-bit policy input then combines these facts into a replay verdict. A squash releases a slot, and a reissued load starts with fresh samples.

Commits enter on a valid/ready channel and verdicts leave on another, one cycle later. A commit is taken only when `commit_ready_o` is high, which holds when no verdict is waiting or the waiting verdict is taken in the same cycle. A verdict stays on the output, unchanged, until `verdict_ready_i` is high. Issue, squash, fill and invalidate are plain single-cycle strobes.

Top module: `load_replay_filter`

## Requirements
- R1: With policy code 2'b00 (replay everything), every committed load gets replay = 1.
- R2: With policy code 2'b01 (hoisting filter), a tracked load gets replay = 1 exactly when `issue_reordered_i` was 1 at its issue. Its store flag and all fill and invalidate events have no effect.
- R3: With policy codes 2'b10 and 2'b11, a tracked load whose `issue_unres_i` was 1 at issue gets replay = 1, whatever events occurred.
- R4: With policy code 2'b10 (invalidate filter), a tracked load with a clear store flag gets replay = 1 exactly when at least one `inval_i` pulse came in its window. The window runs from its issue cycle to its commit-acceptance cycle, both ends included. Fill pulses have no effect.
- R5: With policy code 2'b11 (fill filter), a tracked load with a clear store flag gets replay = 1 exactly when at least one `fill_i` pulse came in the same inclusive window. Invalidate pulses have no effect.
- R6: Event detection holds for any number of events in the window, including an exact multiple of 2^EPOCH_W.
- R7: A commit whose tag has no live entry (never issued, squashed, or already committed) gets replay = 1 under every policy.
- R8: A squash releases its slot. When the same tag is issued again, none of the flags or event history of the squashed instance carries over.
- R9: A verdict appears on `verdict_valid_o` one cycle after its commit is accepted, carrying that commit's tag. While `verdict_ready_i` is low it holds its tag and value, and `commit_ready_o` is low.
- R10: After reset, `verdict_valid_o` is 0, `commit_ready_o` is 1, and no slot is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Replay policy code, sampled at commit acceptance |
| issue_valid_i | input | 1 | A load issues this cycle |
| issue_tag_i | input | TAG_W | Slot of the issuing load |
| issue_reordered_i | input | 1 | The issuing load bypassed older memory operations |
| issue_unres_i | input | 1 | Some older store address is still unknown |
| squash_valid_i | input | 1 | A load is squashed this cycle |
| squash_tag_i | input | TAG_W | Slot of the squashed load |
| fill_i | input | 1 | A cache line fill, to any address, happened this cycle |
| inval_i | input | 1 | An external invalidate, to any address, arrived this cycle |
| commit_valid_i | input | 1 | A load offers to commit |
| commit_ready_o | output | 1 | Commit channel can accept |
| commit_tag_i | input | TAG_W | Slot of the committing load |
| verdict_valid_o | output | 1 | A replay verdict is presented |
| verdict_ready_i | input | 1 | Consumer takes the verdict |
| verdict_tag_o | output | TAG_W | Slot the verdict belongs to |
| verdict_replay_o | output | 1 | 1 = the load must be replayed |

## Verification
Each policy is tried against loads that differ in one fact only: a hoisted load against one in order, a load behind an unknown store against one with clean history, and a fill against an invalidate in the window. This shows that each policy reads its own facts and ignores the others. Events that land in the issue cycle or the commit cycle probe the two ends of the window. A burst of exactly sixteen fills separates true event detection from plain counter comparison. Squash-then-reissue of a tag that has a dirty history, and commits of dead tags, show that state is released. A held verdict while a second commit waits shows the back-pressure rules.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

  typedef enum logic [1:0] {
    POL_REPLAY_ALL  = 2'b00,
    POL_NO_REORDER  = 2'b01,
    POL_UNRES_SNOOP = 2'b10,
    POL_UNRES_MISS  = 2'b11
  } policy_e;

  localparam int EV_FILL  = 0;
  localparam int EV_INVAL = 1;
  localparam int NUM_EV   = 2;

  typedef struct packed {
    logic              live;
    logic              reordered;
    logic              unres;
    logic [NUM_EV-1:0] seen;
  } slot_view_t;

endpackage

// File: rtl/lrf_epoch.sv
module lrf_epoch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (ev_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_EPOCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i |=> cnt_o == W'($past(cnt_o) + 1'b1)); // R6
  AST_EPOCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_i |=> $stable(cnt_o)); // R6

endmodule

// File: rtl/lrf_slot_table.sv
module lrf_slot_table
  import lrf_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int EPOCH_W = 4,
  localparam int TAG_W  = $clog2(SLOTS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           issue_v_i,
  input  logic [TAG_W-1:0]               issue_tag_i,
  input  logic                           issue_reord_i,
  input  logic                           issue_unres_i,
  input  logic                           squash_v_i,
  input  logic [TAG_W-1:0]               squash_tag_i,
  input  logic                           rel_v_i,
  input  logic [TAG_W-1:0]               rel_tag_i,
  input  logic [NUM_EV-1:0]              ev_i,
  input  logic [NUM_EV-1:0][EPOCH_W-1:0] cnt_i,
  input  logic [TAG_W-1:0]               rd_tag_i,
  output slot_view_t                     rd_o
);

  logic [NUM_EV-1:0][EPOCH_W-1:0] cnt_nxt;
  always_comb begin
    for (int e = 0; e < NUM_EV; e++) cnt_nxt[e] = cnt_i[e] + 1'b1;
  end

  logic [SLOTS-1:0]                              live_vec;
  logic [SLOTS-1:0]                              reord_vec;
  logic [SLOTS-1:0]                              unres_vec;
  logic [SLOTS-1:0][NUM_EV-1:0]                  lap_vec;
  logic [SLOTS-1:0][NUM_EV-1:0][EPOCH_W-1:0]     samp_vec;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic                           live_q, reord_q, unres_q;
    logic [NUM_EV-1:0]              lap_q;
    logic [NUM_EV-1:0][EPOCH_W-1:0] samp_q;
    logic hit_issue, hit_drop;

    assign hit_issue = issue_v_i && (issue_tag_i == TAG_W'(s));
    assign hit_drop  = (squash_v_i && (squash_tag_i == TAG_W'(s))) ||
                       (rel_v_i && (rel_tag_i == TAG_W'(s)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q  <= 1'b0;
        reord_q <= 1'b0;
        unres_q <= 1'b0;
        lap_q   <= '0;
        samp_q  <= '0;
      end else if (hit_issue) begin
        live_q  <= 1'b1;
        reord_q <= issue_reord_i;
        unres_q <= issue_unres_i;
        lap_q   <= '0;
        samp_q  <= cnt_i;
      end else begin
        if (hit_drop) live_q <= 1'b0;
        for (int e = 0; e < NUM_EV; e++) begin
          if (live_q && ev_i[e] && (cnt_nxt[e] == samp_q[e])) lap_q[e] <= 1'b1;
        end
      end
    end

    assign live_vec[s]  = live_q;
    assign reord_vec[s] = reord_q;
    assign unres_vec[s] = unres_q;
    assign lap_vec[s]   = lap_q;
    assign samp_vec[s]  = samp_q;
  end

  always_comb begin
    rd_o.live      = live_vec[rd_tag_i];
    rd_o.reordered = reord_vec[rd_tag_i];
    rd_o.unres     = unres_vec[rd_tag_i];
    for (int e = 0; e < NUM_EV; e++) begin
      rd_o.seen[e] = ev_i[e] || lap_vec[rd_tag_i][e] ||
                     (samp_vec[rd_tag_i][e] != cnt_i[e]);
    end
  end

  AST_SQUASH_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_v_i && !(issue_v_i && issue_tag_i == squash_tag_i))
      |=> !live_vec[$past(squash_tag_i)]); // R8
  AST_ISSUE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v_i |=> live_vec[$past(issue_tag_i)] && (lap_vec[$past(issue_tag_i)] == '0)); // R8

endmodule

// File: rtl/lrf_policy.sv
module lrf_policy
  import lrf_pkg::*;
(
  input  policy_e    mode_i,
  input  slot_view_t view_i,
  output logic       replay_o
);

  always_comb begin
    if (!view_i.live) begin
      replay_o = 1'b1;
    end else begin
      unique case (mode_i)
        POL_REPLAY_ALL:  replay_o = 1'b1;
        POL_NO_REORDER:  replay_o = view_i.reordered;
        POL_UNRES_SNOOP: replay_o = view_i.unres || view_i.seen[EV_INVAL];
        POL_UNRES_MISS:  replay_o = view_i.unres || view_i.seen[EV_FILL];
        default:         replay_o = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/load_replay_filter.sv
module load_replay_filter
  import lrf_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int EPOCH_W = 4,
  localparam int TAG_W  = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             issue_valid_i,
  input  logic [TAG_W-1:0] issue_tag_i,
  input  logic             issue_reordered_i,
  input  logic             issue_unres_i,
  input  logic             squash_valid_i,
  input  logic [TAG_W-1:0] squash_tag_i,
  input  logic             fill_i,
  input  logic             inval_i,
  input  logic             commit_valid_i,
  output logic             commit_ready_o,
  input  logic [TAG_W-1:0] commit_tag_i,
  output logic             verdict_valid_o,
  input  logic             verdict_ready_i,
  output logic [TAG_W-1:0] verdict_tag_o,
  output logic             verdict_replay_o
);

  logic [NUM_EV-1:0]              ev_vec;
  logic [NUM_EV-1:0][EPOCH_W-1:0] cnt_vec;

  assign ev_vec[EV_FILL]  = fill_i;
  assign ev_vec[EV_INVAL] = inval_i;

  for (genvar e = 0; e < NUM_EV; e++) begin : g_epoch
    lrf_epoch #(.W(EPOCH_W)) u_epoch (
      .clk   (clk),
      .rst_n (rst_n),
      .ev_i  (ev_vec[e]),
      .cnt_o (cnt_vec[e])
    );
  end

  logic       commit_fire;
  slot_view_t view;
  logic       replay_c;

  lrf_slot_table #(.SLOTS(SLOTS), .EPOCH_W(EPOCH_W)) u_table (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_v_i     (issue_valid_i),
    .issue_tag_i   (issue_tag_i),
    .issue_reord_i (issue_reordered_i),
    .issue_unres_i (issue_unres_i),
    .squash_v_i    (squash_valid_i),
    .squash_tag_i  (squash_tag_i),
    .rel_v_i       (commit_fire),
    .rel_tag_i     (commit_tag_i),
    .ev_i          (ev_vec),
    .cnt_i         (cnt_vec),
    .rd_tag_i      (commit_tag_i),
    .rd_o          (view)
  );

  lrf_policy u_policy (
    .mode_i   (policy_e'(mode_i)),
    .view_i   (view),
    .replay_o (replay_c)
  );

  logic             vv_q, rep_q;
  logic [TAG_W-1:0] vtag_q;

  assign commit_ready_o = !vv_q || verdict_ready_i;
  assign commit_fire    = commit_valid_i && commit_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vv_q   <= 1'b0;
      rep_q  <= 1'b0;
      vtag_q <= '0;
    end else if (commit_fire) begin
      vv_q   <= 1'b1;
      rep_q  <= replay_c;
      vtag_q <= commit_tag_i;
    end else if (verdict_ready_i) begin
      vv_q   <= 1'b0;
    end
  end

  assign verdict_valid_o  = vv_q;
  assign verdict_tag_o    = vtag_q;
  assign verdict_replay_o = rep_q;

  AST_ALL_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && mode_i == 2'b00) |=> verdict_valid_o && verdict_replay_o); // R1
  AST_UNRES_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && mode_i[1] && view.live && view.unres) |=> verdict_replay_o); // R3
  AST_DEAD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && !view.live) |=> verdict_replay_o); // R7
  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid_o && !verdict_ready_i)
      |=> verdict_valid_o && $stable(verdict_tag_o) && $stable(verdict_replay_o)); // R9
  AST_VERDICT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> verdict_valid_o && verdict_tag_o == $past(commit_tag_i)); // R9

endmodule

// File: tb/load_replay_filter_tb.sv
module load_replay_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       issue_valid_i = 0, issue_reordered_i = 0, issue_unres_i = 0;
  logic [3:0] issue_tag_i = '0, squash_tag_i = '0, commit_tag_i = '0;
  logic       squash_valid_i = 0, fill_i = 0, inval_i = 0;
  logic       commit_valid_i = 0, verdict_ready_i = 1;
  logic       commit_ready_o, verdict_valid_o, verdict_replay_o;
  logic [3:0] verdict_tag_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_replay_filter u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .issue_valid_i(issue_valid_i), .issue_tag_i(issue_tag_i),
    .issue_reordered_i(issue_reordered_i), .issue_unres_i(issue_unres_i),
    .squash_valid_i(squash_valid_i), .squash_tag_i(squash_tag_i),
    .fill_i(fill_i), .inval_i(inval_i),
    .commit_valid_i(commit_valid_i), .commit_ready_o(commit_ready_o),
    .commit_tag_i(commit_tag_i),
    .verdict_valid_o(verdict_valid_o), .verdict_ready_i(verdict_ready_i),
    .verdict_tag_o(verdict_tag_o), .verdict_replay_o(verdict_replay_o)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(int tag, bit reord, bit unres, bit with_fill = 0);
    @(negedge clk);
    issue_valid_i = 1; issue_tag_i = 4'(tag);
    issue_reordered_i = reord; issue_unres_i = unres; fill_i = with_fill;
    @(negedge clk);
    issue_valid_i = 0; fill_i = 0;
  endtask

  task automatic pulse(bit f, bit v, int n);
    @(negedge clk);
    fill_i = f; inval_i = v;
    repeat (n) @(negedge clk);
    fill_i = 0; inval_i = 0;
  endtask

  task automatic squash(int tag);
    @(negedge clk);
    squash_valid_i = 1; squash_tag_i = 4'(tag);
    @(negedge clk);
    squash_valid_i = 0;
  endtask

  task automatic commit(string req, int tag, logic [1:0] mode, int exp,
                        bit f = 0, bit v = 0);
    @(negedge clk);
    commit_valid_i = 1; commit_tag_i = 4'(tag); mode_i = mode;
    fill_i = f; inval_i = v;
    @(negedge clk);
    commit_valid_i = 0; fill_i = 0; inval_i = 0;
    chk({req, " verdict valid"}, int'(verdict_valid_o), 1);
    chk({req, " verdict tag"}, int'(verdict_tag_o), tag);
    chk({req, " replay"}, int'(verdict_replay_o), exp);
  endtask

  task automatic t_reset();
    chk("R10 verdict_valid after reset", int'(verdict_valid_o), 0);
    chk("R10 commit_ready after reset", int'(commit_ready_o), 1);
    commit("R10 no live slot after reset", 5, 2'b01, 1);
  endtask

  task automatic t_replay_all();
    issue(1, 0, 0);
    commit("R1 clean load still replays", 1, 2'b00, 1);
  endtask

  task automatic t_no_reorder();
    issue(2, 0, 1);
    pulse(1, 1, 2);
    commit("R2 in-order load skips despite events", 2, 2'b01, 0);
    issue(3, 1, 0);
    commit("R2 hoisted load replays", 3, 2'b01, 1);
  endtask

  task automatic t_unres();
    issue(4, 0, 1);
    commit("R3 unresolved store, fill filter", 4, 2'b11, 1);
    issue(5, 0, 1);
    commit("R3 unresolved store, invalidate filter", 5, 2'b10, 1);
  endtask

  task automatic t_snoop();
    issue(6, 1, 0);
    pulse(1, 0, 3);
    commit("R4 fills ignored", 6, 2'b10, 0);
    issue(7, 0, 0);
    pulse(0, 1, 1);
    commit("R4 invalidate in window", 7, 2'b10, 1);
    issue(8, 0, 0);
    commit("R4 invalidate in commit cycle", 8, 2'b10, 1, 0, 1);
  endtask

  task automatic t_miss();
    issue(9, 1, 0);
    pulse(0, 1, 2);
    commit("R5 invalidates ignored", 9, 2'b11, 0);
    issue(10, 0, 0);
    pulse(1, 0, 1);
    commit("R5 fill in window", 10, 2'b11, 1);
    issue(11, 0, 0, 1);
    commit("R5 fill in issue cycle", 11, 2'b11, 1);
    issue(12, 0, 0);
    commit("R5 quiet window", 12, 2'b11, 0);
  endtask

  task automatic t_wrap();
    issue(13, 0, 0);
    pulse(1, 0, 16);
    commit("R6 sixteen fills", 13, 2'b11, 1);
    issue(13, 0, 0);
    pulse(0, 1, 32);
    commit("R6 thirty-two invalidates", 13, 2'b10, 1);
  endtask

  task automatic t_untracked();
    commit("R7 never issued", 14, 2'b11, 1);
    commit("R7 already committed", 10, 2'b01, 1);
  endtask

  task automatic t_squash();
    issue(15, 1, 1);
    pulse(1, 1, 1);
    squash(15);
    commit("R7 squashed tag", 15, 2'b11, 1);
    issue(15, 1, 1);
    pulse(1, 0, 1);
    squash(15);
    issue(15, 0, 0);
    commit("R8 fresh samples after reissue", 15, 2'b11, 0);
    issue(0, 1, 0);
    squash(0);
    issue(0, 0, 0);
    commit("R8 fresh flags after reissue", 0, 2'b01, 0);
  endtask

  task automatic t_backpressure();
    issue(1, 0, 0);
    issue(2, 1, 0);
    @(negedge clk);
    verdict_ready_i = 0;
    commit_valid_i = 1; commit_tag_i = 4'd1; mode_i = 2'b01;
    @(negedge clk);
    commit_tag_i = 4'd2;
    chk("R9 first verdict tag", int'(verdict_tag_o), 1);
    chk("R9 first verdict replay", int'(verdict_replay_o), 0);
    chk("R9 commit blocked", int'(commit_ready_o), 0);
    repeat (2) @(negedge clk);
    chk("R9 verdict held valid", int'(verdict_valid_o), 1);
    chk("R9 verdict tag held", int'(verdict_tag_o), 1);
    chk("R9 commit still blocked", int'(commit_ready_o), 0);
    verdict_ready_i = 1;
    @(negedge clk);
    commit_valid_i = 0;
    chk("R9 second verdict valid", int'(verdict_valid_o), 1);
    chk("R9 second verdict tag", int'(verdict_tag_o), 2);
    chk("R9 second verdict replay", int'(verdict_replay_o), 1);
    @(negedge clk);
    chk("R9 verdict drained", int'(verdict_valid_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_replay_all();
    t_no_reorder();
    t_unres();
    t_snoop();
    t_miss();
    t_wrap();
    t_untracked();
    t_squash();
    t_backpressure();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule